// File: doc/BRIEF.md
# Timer Input Capture Unit

The unit watches one asynchronous input pin and, when a selected event occurs on it, copies the 16-bit value of an external free-running timer into a capture register. Both halves of the timer value are taken on the same clock edge, so software never sees a torn value. The event can be a falling edge, a rising edge, or every 4th or 16th rising edge. The edge choice and the event prescaler share one 4-bit mode field.

Each capture sets a sticky flag that only software can clear. An enable bit gates the flag onto the interrupt output. A capture that arrives before software has read the previous value replaces that value, and nothing records that this happened. The prescaler counter clears only when the unit is off, in a non-capture mode, or in reset. A direct change from one prescale ratio to the other keeps the count, so the first capture after the change can come early.

Registers are reached through a byte-wide port. Writes are strobed and reads are combinational. Address 0 is control, address 1 is status, and addresses 2 and 3 hold the capture value.

Top module: `tmr_capture_unit`

## Requirements
- R1: A pin level present at clock edge n passes two synchronizer flops. A qualifying transition is recognised between edges n+1 and n+2. The capture register then holds the timer value that was applied at edge n+2, readable after that edge.
- R2: Mode 4'b0100 captures on every falling edge of the synchronized pin and on no rising edge.
- R3: Mode 4'b0101 captures on every rising edge of the synchronized pin and on no falling edge.
- R4: Mode 4'b0110 counts rising edges in a 4-bit counter. The edge that finds the count at 3 or more captures and resets the count to 0. Any other rising edge increments the count.
- R5: Mode 4'b0111 follows the same rule as R4, with a threshold of 15.
- R6: Switching directly between 4'b0110 and 4'b0111 leaves the prescale count unchanged. The next capture follows the new threshold from the count already held, so with a held count of 3 or more under 4'b0110 the very next rising edge captures.
- R7: Any mode whose two upper bits are not 2'b01 (off is 4'b0000) makes no capture and clears the prescale count on every cycle.
- R8: Every capture sets the flag, read at address 1 bit 0. Writing address 1 with bit 0 set clears the flag. A capture in the same cycle as that clear leaves the flag set. Nothing else clears the flag.
- R9: A new capture overwrites the held value even if it has not been read. Address 2 reads the low byte and address 3 reads the high byte.
- R10: The interrupt output equals the flag ANDed with the enable bit, which is control register (address 0) bit 4. Control bits 3:0 hold the mode. Address 0 reads back {3'b000, enable, mode}.
- R11: After reset every register reads zero, the prescale count is zero and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 1 | Asynchronous event pin |
| timerVal | input | 16 | Current free-running timer value |
| regAddr | input | 2 | Register address for read and write |
| regWe | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Combinational read data at regAddr |
| irq | output | 1 | Interrupt request (flag AND enable) |

## Verification
The hardest case to reach from the ports is the early capture after a direct change of prescale ratio. It needs a specific count held in the prescaler at the moment the mode field is rewritten without passing through off. The stimulus builds the count with a known number of synthesized rising edges under divide-by-16, then writes divide-by-4 directly. It also does the reverse from a low count. Flag-clear writes are issued on every cycle during busy pin traffic, so clears collide with captures. A behavioural model compares the interrupt output and a rotating register read on every clock.

// File: rtl/capt_pkg.sv
package capt_pkg;

  typedef enum logic [3:0] {
    MODE_OFF  = 4'b0000,
    MODE_FALL = 4'b0100,
    MODE_RISE = 4'b0101,
    MODE_DIV4 = 4'b0110,
    MODE_DIV16 = 4'b0111
  } captMode_e;

  typedef struct packed {
    logic capture;
    logic flagClr;
    logic irqEn;
  } captStrobes_t;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_STATUS = 2'd1;
  localparam int unsigned ADDR_CAP_BASE = 2;

endpackage

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PS_W = 4,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [4:0]        ctrlWr,
  output captStrobes_t      strb,
  output logic [3:0]        modeQ
);

  localparam logic [PS_W-1:0] LIM_DIV4  = PS_W'(3);
  localparam logic [PS_W-1:0] LIM_DIV16 = PS_W'(15);

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic ieQ;
  logic [PS_W-1:0] cntQ;
  logic [PS_W-1:0] cntD;
  logic synced, rise, fall, capMode, capHit;
  logic [PS_W-1:0] limit;

  // pin synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign synced = syncQ[SYNC_STAGES-1];
  assign rise = synced & ~prevQ;
  assign fall = ~synced & prevQ;
  assign capMode = (modeQ[3:2] == 2'b01);
  assign limit = (modeQ == MODE_DIV4) ? LIM_DIV4 : LIM_DIV16;

  always_comb begin
    capHit = 1'b0;
    cntD = cntQ;
    if (!capMode) begin
      cntD = '0;
    end else begin
      unique case (modeQ)
        MODE_FALL: capHit = fall;
        MODE_RISE: capHit = rise;
        default: begin
          if (rise) begin
            if (cntQ >= limit) begin
              capHit = 1'b1;
              cntD = '0;
            end else begin
              cntD = cntQ + PS_W'(1);
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_OFF;
      ieQ <= 1'b0;
      cntQ <= '0;
    end else begin
      cntQ <= cntD;
      if (regWe && regAddr == ADDR_CTRL) begin
        modeQ <= ctrlWr[3:0];
        ieQ <= ctrlWr[4];
      end
    end
  end

  assign strb.capture = capHit;
  assign strb.flagClr = regWe && (regAddr == ADDR_STATUS) && ctrlWr[0];
  assign strb.irqEn = ieQ;

  a_r7_cnt_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !capMode |=> cntQ == '0);
  a_r7_no_capture_off: assert property (@(posedge clk) disable iff (!rstN)
    !capMode |-> !strb.capture);
  a_r4_cnt_wraps: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && modeQ[1] |=> cntQ == '0);

endmodule

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
#(
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  captStrobes_t       strb,
  input  logic [3:0]         modeQ,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic [ADDR_W-1:0]  regAddr,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irq
);

  localparam int unsigned BYTES = TIMER_W / DATA_W;

  logic [TIMER_W-1:0] capQ;
  logic flagQ;
  logic [DATA_W-1:0] capBytes [BYTES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ <= '0;
      flagQ <= 1'b0;
    end else begin
      if (strb.capture) capQ <= timerVal;
      if (strb.capture) flagQ <= 1'b1;
      else if (strb.flagClr) flagQ <= 1'b0;
    end
  end

  generate
    for (genvar b = 0; b < BYTES; b++) begin : g_bytes
      assign capBytes[b] = capQ[b*DATA_W +: DATA_W];
    end
  endgenerate

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_CTRL) begin
      regRdData[3:0] = modeQ;
      regRdData[4] = strb.irqEn;
    end else if (regAddr == ADDR_STATUS) begin
      regRdData[0] = flagQ;
    end else begin
      for (int b = 0; b < BYTES; b++) begin
        if (int'(regAddr) == ADDR_CAP_BASE + b) regRdData = capBytes[b];
      end
    end
  end

  assign irq = flagQ & strb.irqEn;

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> flagQ);
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    flagQ && !strb.flagClr |=> flagQ);
  a_r9_value_loaded: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> capQ == $past(timerVal));
  a_r9_value_held: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(capQ));

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
  import capt_pkg::*;
#(
  parameter int unsigned TIMER_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PS_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pinIn,
  input  logic [TIMER_W-1:0] timerVal,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irq
);

  captStrobes_t strb;
  logic [3:0] modeQ;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:5];

  capt_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .PS_W(PS_W),
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .pinIn(pinIn),
    .regWe(regWe),
    .regAddr(regAddr),
    .ctrlWr(regWrData[4:0]),
    .strb(strb),
    .modeQ(modeQ)
  );

  capt_datapath #(
    .TIMER_W(TIMER_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .modeQ(modeQ),
    .timerVal(timerVal),
    .regAddr(regAddr),
    .regRdData(regRdData),
    .irq(irq)
  );

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> strb.irqEn);

endmodule

// File: tb/tmr_capture_unit_test.sv
`timescale 1ns/1ps
module tmr_capture_unit_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinIn = 1'b0;
  logic [15:0] timerVal = '0;
  logic [1:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irq;

  int checks = 0;
  int errors = 0;
  string curReq = "R11 reset";
  logic [1:0] rdSel = '0;

  always #2 clk = ~clk;

  tmr_capture_unit uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .timerVal(timerVal),
    .regAddr(regAddr), .regWe(regWe), .regWrData(regWrData),
    .regRdData(regRdData), .irq(irq)
  );

  // behavioural reference
  bit pinHist[$] = '{0, 0, 0};
  int mMode = 0, mIe = 0, mCnt = 0, mFlag = 0, mCap = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinHist = '{0, 0, 0};
      mMode = 0; mIe = 0; mCnt = 0; mFlag = 0; mCap = 0;
    end else begin
      bit seenNew, seenOld, isRise, isFall, doCap;
      int lim;
      seenNew = pinHist[1];
      seenOld = pinHist[0];
      isRise = seenNew && !seenOld;
      isFall = !seenNew && seenOld;
      doCap = 0;
      if (mMode < 4 || mMode > 7) mCnt = 0;
      else if (mMode == 4) doCap = isFall;
      else if (mMode == 5) doCap = isRise;
      else if (isRise) begin
        lim = (mMode == 6) ? 3 : 15;
        if (mCnt >= lim) begin doCap = 1; mCnt = 0; end
        else mCnt = mCnt + 1;
      end
      if (doCap) begin mCap = timerVal; mFlag = 1; end
      else if (regWe && regAddr == 2'd1 && regWrData[0]) mFlag = 0;
      if (regWe && regAddr == 2'd0) begin
        mMode = regWrData[3:0];
        mIe = regWrData[4];
      end
      void'(pinHist.pop_front());
      pinHist.push_back(pinIn);
    end
  end

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {3'b000, 1'(mIe), 4'(mMode)};
      2'd1: return {7'b0, 1'(mFlag)};
      2'd2: return 8'(mCap);
      default: return 8'(mCap >> 8);
    endcase
  endfunction

  task automatic compareNow();
    logic [7:0] e;
    logic ei;
    e = expRead(regAddr);
    ei = 1'(mFlag & mIe);
    checks++;
    if (regRdData !== e) begin
      errors++;
      $display("FAIL %s: read addr %0d actual %02h expected %02h", curReq, regAddr, regRdData, e);
    end
    checks++;
    if (irq !== ei) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", curReq, irq, ei);
    end
  endtask

  task automatic tick(input bit we, input logic [1:0] a, input logic [7:0] d, input logic p);
    @(negedge clk);
    compareNow();
    regWe = we;
    regAddr = we ? a : rdSel;
    rdSel = rdSel + 2'd1;
    regWrData = d;
    pinIn = p;
    timerVal = 16'($urandom);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, pinIn);
  endtask

  task automatic setCtrl(input int mode, input int ie);
    tick(1, 2'd0, 8'((ie << 4) | mode), pinIn);
  endtask

  // random pin traffic; clearPct chance of a flag-clear write per cycle
  task automatic traffic(input int n, input int clearPct);
    for (int i = 0; i < n; i++) begin
      logic p;
      p = ($urandom_range(3) == 0) ? ~pinIn : pinIn;
      if ($urandom_range(99) < clearPct) tick(1, 2'd1, 8'h01, p);
      else tick(0, 0, 0, p);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      tick(0, 0, 0, 1'b1);
      tick(0, 0, 0, 1'b1);
      tick(0, 0, 0, 1'b0);
      tick(0, 0, 0, 1'b0);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R11 reset";
    idle(8);

    curReq = "R1 R3 rising";
    setCtrl(5, 1);
    traffic(300, 10);

    curReq = "R2 falling";
    setCtrl(4, 1);
    traffic(300, 10);

    curReq = "R4 div4";
    setCtrl(0, 1);
    setCtrl(6, 1);
    traffic(400, 10);

    curReq = "R5 div16";
    setCtrl(0, 1);
    setCtrl(7, 1);
    traffic(800, 10);

    curReq = "R6 switch 16 to 4";
    setCtrl(0, 1);
    setCtrl(7, 1);
    pulses(10);
    setCtrl(6, 1);
    pulses(3);
    idle(4);
    curReq = "R6 switch 4 to 16";
    setCtrl(0, 1);
    setCtrl(6, 1);
    pulses(2);
    setCtrl(7, 1);
    pulses(18);
    idle(4);

    curReq = "R7 non-capture modes";
    setCtrl(7, 1);
    pulses(5);
    setCtrl(10, 1);
    traffic(100, 0);
    setCtrl(3, 1);
    traffic(100, 0);
    setCtrl(7, 1);
    pulses(17);
    setCtrl(0, 1);
    traffic(100, 0);

    curReq = "R9 overwrite";
    setCtrl(5, 1);
    traffic(300, 0);

    curReq = "R8 clear collides";
    setCtrl(5, 1);
    traffic(300, 100);
    traffic(200, 30);

    curReq = "R10 irq gated";
    setCtrl(5, 0);
    traffic(300, 5);
    setCtrl(5, 1);
    traffic(50, 0);

    idle(8);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule